// File: doc/BRIEF.md
# Bus Transition Activity Monitor

This block sits passively beside an encoded bus and its invert control lines and gathers switching statistics. Each cycle a valid strobe is high, it samples the bus word, made of the data lines and the invert lines, and compares it with the previous sampled word. The number of lines that toggled is added to a running switch total. For each configured data segment, a dedicated counter records how many transfers had a raw Hamming distance greater than half the segment width. These are the transfers where inverting that segment would have cut switching. A transfer counter records how many valid words were seen. From these figures a testbench or a register read computes switches per transfer and the share of transfers that would benefit from inversion.

A small state machine tracks whether a reference word exists. `ST_SEEK_FIRST` is entered on reset and on a clear. A valid word in that state becomes the reference and causes transition `T_SEED` to `ST_TRACK`. In `ST_TRACK`, valid words are compared and accumulated and the state stays put (`T_STAY`). A clear from either state causes transition `T_RESEED` back to `ST_SEEK_FIRST`. All counters saturate rather than wrap.

Top module: `bus_toggle_monitor`

## Requirements
- R1: After reset all counters read zero, and the next valid word is taken as the reference word.
- R2: The first valid word after reset or clear adds nothing to the switch total or to any segment counter, but does increment the transfer counter.
- R3: Every later valid word adds to the switch total the count of ones in the XOR of the word `{bus_inv, bus_data}` with the previous valid word.
- R4: A toggle on an invert control line alone adds one per toggled line to the switch total.
- R5: Segment counter k (bits `[SEG_LO_k + SEG_WID_k - 1 : SEG_LO_k]` of `bus_data`, field k of `seg_hits`, field 0 at the LSBs) increments when twice that segment's Hamming distance exceeds its width; a distance of exactly half the width does not count.
- R6: Cycles with `valid` low change no counter and leave the reference word unchanged.
- R7: `clear` is synchronous: one cycle later every counter reads zero and the next valid word is a new reference; a word presented with `valid` on the same cycle as `clear` is discarded.
- R8: Every counter saturates at 2^CNT_W - 1 instead of wrapping.
- R9: A transfer sampled on a clock edge is reflected in the counter outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all counters and the reference word |
| valid | input | 1 | Bus word on this cycle is a transfer |
| bus_data | input | DATA_W | Observed data lines |
| bus_inv | input | CTRL_W | Observed invert control lines |
| total_toggles | output | CNT_W | Saturating sum of toggles on data and invert lines |
| transfer_count | output | CNT_W | Saturating count of valid transfers |
| seg_hits | output | NUM_SEG*CNT_W | Per-segment saturating count of over-half transfers |

## Verification
The bench first aims at the reference-word rules: a design that counted the first word against a zero bus would inflate the total, and one that updated the reference on idle cycles would measure the next delta against the wrong word. It then presses the segment threshold at exactly half width, where an off-by-one compare would count a distance of two on a four-bit segment. A clear raised together with a valid word shows whether that word is wrongly kept as the reference. A long sweep over every 9-bit word value drives the switch total into saturation; a wrapping counter would fall back to a small value there.

// File: rtl/btm_pkg.sv
package btm_pkg;
    typedef enum logic {
        ST_SEEK_FIRST = 1'b0,
        ST_TRACK      = 1'b1
    } btm_state_e;
endpackage

// File: rtl/btm_popcount.sv
module btm_popcount #(
    parameter int IN_W  = 8,
    parameter int OUT_W = $clog2(IN_W + 1)
) (
    input  logic [IN_W-1:0]  vec,
    output logic [OUT_W-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < IN_W; i++) begin
            ones = ones + OUT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/btm_sat_acc.sv
module btm_sat_acc #(
    parameter int CNT_W = 32,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] q
);
    logic [CNT_W:0] sum;

    always_comb begin
        sum = {1'b0, q} + (CNT_W+1)'(inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (en) begin
            if (sum[CNT_W]) q <= '1;
            else            q <= sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/bus_toggle_monitor.sv
module bus_toggle_monitor #(
    parameter int                 DATA_W  = 40,
    parameter int                 CTRL_W  = 3,
    parameter int                 NUM_SEG = 3,
    parameter logic [NUM_SEG*8-1:0] SEG_LO  = {8'd24, 8'd16, 8'd0},
    parameter logic [NUM_SEG*8-1:0] SEG_WID = {8'd8, 8'd8, 8'd6},
    parameter int                 CNT_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     valid,
    input  logic [DATA_W-1:0]        bus_data,
    input  logic [CTRL_W-1:0]        bus_inv,
    output logic [CNT_W-1:0]         total_toggles,
    output logic [CNT_W-1:0]         transfer_count,
    output logic [NUM_SEG*CNT_W-1:0] seg_hits
);
    import btm_pkg::*;

    localparam int BUS_W = DATA_W + CTRL_W;
    localparam int HD_W  = $clog2(BUS_W + 1);

    btm_state_e state_q, state_d;
    logic [BUS_W-1:0] word_now, word_ref, word_diff;
    logic [HD_W-1:0]  word_hd;
    logic             take, compare_en;

    assign word_now  = {bus_inv, bus_data};
    assign word_diff = word_now ^ word_ref;
    assign take      = valid && !clear;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEK_FIRST;
        else        state_q <= state_d;
    end

    // Transitions: T_SEED, T_STAY, T_RESEED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK_FIRST: if (clear) state_d = ST_SEEK_FIRST;
                           else if (valid) state_d = ST_TRACK;
            ST_TRACK:      if (clear) state_d = ST_SEEK_FIRST;
                           else state_d = ST_TRACK;
            default:       state_d = ST_SEEK_FIRST;
        endcase
    end

    // Outputs of the state machine: accumulate enable and reference word
    always_comb begin
        compare_en = 1'b0;
        unique case (state_q)
            ST_SEEK_FIRST: compare_en = 1'b0;
            ST_TRACK:      compare_en = take;
            default:       compare_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_ref <= '0;
        else if (take) word_ref <= word_now;
    end

    btm_popcount #(.IN_W(BUS_W), .OUT_W(HD_W)) bus_pop_i (
        .vec  (word_diff),
        .ones (word_hd)
    );

    btm_sat_acc #(.CNT_W(CNT_W), .INC_W(HD_W)) total_acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .en    (compare_en),
        .inc   (word_hd),
        .q     (total_toggles)
    );

    btm_sat_acc #(.CNT_W(CNT_W), .INC_W(1)) xfer_acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .en    (take),
        .inc   (1'b1),
        .q     (transfer_count)
    );

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam int SLO  = int'(SEG_LO[g*8 +: 8]);
        localparam int SW   = int'(SEG_WID[g*8 +: 8]);
        localparam int SHDW = $clog2(SW + 1);
        logic [SHDW-1:0] seg_hd;
        logic            over_half;

        btm_popcount #(.IN_W(SW), .OUT_W(SHDW)) seg_pop_i (
            .vec  (word_diff[SLO +: SW]),
            .ones (seg_hd)
        );

        assign over_half = (int'(seg_hd) * 2) > SW;

        btm_sat_acc #(.CNT_W(CNT_W), .INC_W(1)) seg_acc_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear),
            .en    (compare_en && over_half),
            .inc   (1'b1),
            .q     (seg_hits[g*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/btm_checker.sv
module btm_checker #(
    parameter int CNT_W   = 32,
    parameter int NUM_SEG = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clear,
    input logic                     valid,
    input logic [CNT_W-1:0]         total_toggles,
    input logic [CNT_W-1:0]         transfer_count,
    input logic [NUM_SEG*CNT_W-1:0] seg_hits
);
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clear) |=> ($stable(total_toggles) && $stable(transfer_count) && $stable(seg_hits)));

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (total_toggles == '0 && transfer_count == '0 && seg_hits == '0));

    a_r3_total_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (total_toggles >= $past(total_toggles)));

    a_r8_xfer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clear) |=> ((transfer_count == CNT_W'($past(transfer_count) + 1'b1))
                               || ((&$past(transfer_count)) && (&transfer_count))));

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_chk
        a_r5_seg_step: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> ((seg_hits[g*CNT_W +: CNT_W] == $past(seg_hits[g*CNT_W +: CNT_W]))
                     || (seg_hits[g*CNT_W +: CNT_W] == CNT_W'($past(seg_hits[g*CNT_W +: CNT_W]) + 1'b1))));
    end
endmodule

bind bus_toggle_monitor btm_checker #(.CNT_W(CNT_W), .NUM_SEG(NUM_SEG)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear          (clear),
    .valid          (valid),
    .total_toggles  (total_toggles),
    .transfer_count (transfer_count),
    .seg_hits       (seg_hits)
);

// File: tb/bus_toggle_monitor_tb.sv
module bus_toggle_monitor_tb_top;
    localparam int DW = 8;
    localparam int CW = 1;
    localparam int NS = 2;
    localparam int NW = 10;
    localparam int MAXC = (1 << NW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic valid = 1'b0;
    logic [DW-1:0] bus_data = '0;
    logic [CW-1:0] bus_inv = '0;
    logic [NW-1:0] total_toggles, transfer_count;
    logic [NS*NW-1:0] seg_hits;

    int n_chk = 0;
    int n_bad = 0;
    int e_tot = 0, e_xfer = 0, e_s0 = 0, e_s1 = 0;
    logic [8:0] e_ref = '0;
    bit e_have = 0;

    always #5 clk = ~clk;

    bus_toggle_monitor #(
        .DATA_W(DW), .CTRL_W(CW), .NUM_SEG(NS),
        .SEG_LO({8'd3, 8'd0}), .SEG_WID({8'd4, 8'd3}), .CNT_W(NW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .valid(valid),
        .bus_data(bus_data), .bus_inv(bus_inv),
        .total_toggles(total_toggles), .transfer_count(transfer_count),
        .seg_hits(seg_hits)
    );

    function automatic int ones9(input logic [8:0] v);
        int c = 0;
        for (int i = 0; i < 9; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic int sat(input int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "total", int'(total_toggles), e_tot);
        cmp(tag, "xfers", int'(transfer_count), e_xfer);
        cmp(tag, "seg0", int'(seg_hits[0 +: NW]), e_s0);
        cmp(tag, "seg1", int'(seg_hits[NW +: NW]), e_s1);
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge (R9)
    task automatic step(input logic [8:0] w, input bit v, input bit c, input string tag);
        logic [8:0] d;
        bus_data = w[7:0];
        bus_inv  = w[8];
        valid    = v;
        clear    = c;
        @(posedge clk);
        if (c) begin
            e_tot = 0; e_xfer = 0; e_s0 = 0; e_s1 = 0; e_have = 0;
        end else if (v) begin
            e_xfer = sat(e_xfer + 1);
            if (e_have) begin
                d = w ^ e_ref;
                e_tot = sat(e_tot + ones9(d));
                if (2 * ones9({6'b0, d[2:0]}) > 3) e_s0 = sat(e_s0 + 1);
                if (2 * ones9({5'b0, d[6:3]}) > 4) e_s1 = sat(e_s1 + 1);
            end
            e_ref = w;
            e_have = 1;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R2: first word is reference only
        step(9'h0A5, 1, 0, "R2 first word");
        // R3: plain data delta
        step(9'h05A, 1, 0, "R3 data delta");
        // R4: only the invert line toggles
        step(9'h15A, 1, 0, "R4 inv toggle");
        step(9'h05A, 1, 0, "R4 inv toggle back");
        // R5: seg1 (bits 6:3) distance 2 = half, must not count
        step(9'h05A ^ 9'h018, 1, 0, "R5 seg1 exactly half");
        // R5: seg1 distance 3 counts; seg0 distance 2 of 3 counts
        step(9'h042 ^ 9'h038 ^ 9'h006, 1, 0, "R5 both over half");
        // R6: idle cycles with changing lines
        step(9'h1FF, 0, 0, "R6 idle a");
        step(9'h000, 0, 0, "R6 idle b");
        step(9'h0F0, 1, 0, "R6 delta vs last valid");
        // R7: clear with a valid word on the same cycle
        step(9'h1AB, 1, 1, "R7 clear with valid");
        step(9'h033, 1, 0, "R7 new reference");
        step(9'h0CC, 1, 0, "R7 counting resumes");
        step(9'h000, 0, 1, "R7 plain clear");
        // R3 and R8: sweep every 9-bit value, long enough to saturate
        for (int k = 0; k < 700; k++) begin
            step(9'((k * 149 + 7) % 512), (k % 7) != 3, 0, "R3 sweep");
        end
        cmp("R8 total saturated", "total", int'(total_toggles), MAXC);
        step(9'h1FF, 1, 0, "R8 hold at max");
        cmp("R8 still saturated", "total", int'(total_toggles), MAXC);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule